// File: doc/BRIEF.md
# Z80-Style External Bus Cycle Controller

This block converts single memory or I/O read and write requests from an internal CPU into external bus cycles with classic three-phase timing. A cycle runs through a set-up phase T1, a strobe phase T2, optional wait phases TW and a closing phase T3, and then returns to idle. In T1 the block drives the address and pulls the chip select low. In T2 it asserts the read or write strobe, together with either the memory-request or the I/O-request line. T3 leaves every line unchanged, and a read captures the data bus at the clock edge that closes T3.

A 4-bit setting gives the number of system clocks that each of T1, T2 and T3 lasts. A slow device can stretch a cycle further by holding the active-low wait input low: the block samples that input one clock before T2 ends, and it keeps inserting single-clock wait phases until it samples the input high again. When a cycle completes, the internal side receives a one-clock done pulse together with the read data.

Top module: `zbus_cycle_ctrl`

## Requirements
- R1: After reset, cs, rd, wr, mreq and iorq are all high (deasserted), the data output enable is 0, done is 0, and ext_addr and rsp_rdata are 0.
- R2: T1 is the first cs-low phase. Throughout T1, ext_addr equals the requested address, and rd, wr, mreq and iorq stay high.
- R3: From T2 to the end of the cycle, a read (req_write=0) holds ext_rd_n low and ext_wr_n high. A write (req_write=1) holds ext_wr_n low and ext_rd_n high.
- R4: From T2 to the end of the cycle, a memory access (req_io=0) holds ext_mreq_n low and ext_iorq_n high. An I/O access (req_io=1) does the reverse.
- R5: Each of T1, T2 and T3 lasts N = cfg_clks clocks, where a setting of 0 gives N = 1. Without waits, cs stays low for exactly 3N clocks.
- R6: Let L be the number of leading cs-low clock edges at which ext_wait_n is low. Wait phases are inserted only if ext_wait_n is low at the edge one clock before T2 ends (L >= 2N-1). In that case cs stays low for 3N + L + 2 - 2N clocks, because the block leaves the wait phase on the first clock after it samples the input high.
- R7: No control output changes during T3.
- R8: For a read, rsp_rdata holds the value that ext_data_in had at the clock edge that ends T3.
- R9: For a write, ext_data_oe is 1 and ext_data_out equals the write data on every cs-low clock. ext_data_oe is 0 when the bus is idle.
- R10: rsp_done pulses for exactly one clock, in the clock after T3, while all strobes are high. A request presented in that clock starts the next cycle at once.
- R11: A request raised while a cycle is in progress has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted only in idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| cfg_clks | input | 4 | Clocks per bus phase (0 treated as 1) |
| rsp_rdata | output | DW | Captured read data |
| rsp_done | output | 1 | One-clock completion pulse |
| ext_addr | output | AW | External address bus |
| ext_data_out | output | DW | External data bus, driven value |
| ext_data_oe | output | 1 | External data bus output enable |
| ext_data_in | input | DW | External data bus, received value |
| ext_cs_n | output | 1 | Chip select, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_mreq_n | output | 1 | Memory request, active low |
| ext_iorq_n | output | 1 | I/O request, active low |
| ext_wait_n | input | 1 | Wait request from the device, active low |

## Verification
The bench issues every combination of read or write with memory or I/O, at phase lengths 0, 1, 2, 3 and 15. This separates strobe-select errors from phase-length errors. Wait is released at the edge just too early to count, at the earliest edge that counts, and long after that, which pins down the sampling point and the exit rule. The device changes its data on every clock, so a capture one edge early or late returns the wrong value. A stray request in mid-cycle and a request placed in the done clock test the idle-only acceptance rule and back-to-back cycles.

// File: rtl/zbus_pkg.sv
package zbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4
  } phase_e;

  typedef struct packed {
    logic cs_n;
    logic rd_n;
    logic wr_n;
    logic mreq_n;
    logic iorq_n;
    logic oe;
  } bus_ctl_t;

  localparam bus_ctl_t CTL_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                    mreq_n: 1'b1, iorq_n: 1'b1, oe: 1'b0};

  // Number of clocks in one phase: a setting of zero behaves as one.
  function automatic logic [3:0] eff_len(input logic [3:0] cfg);
    return (cfg == 4'd0) ? 4'd1 : cfg;
  endfunction

  // Pin levels for a given phase.
  function automatic bus_ctl_t ctl_for(input phase_e ph, input logic wr,
                                       input logic io);
    bus_ctl_t c;
    c = CTL_IDLE;
    if (ph != PH_IDLE) begin
      c.cs_n = 1'b0;
      c.oe   = wr;
    end
    if (ph == PH_T2 || ph == PH_TW || ph == PH_T3) begin
      c.rd_n   = wr;
      c.wr_n   = ~wr;
      c.mreq_n = io;
      c.iorq_n = ~io;
    end
    return c;
  endfunction

endpackage

// File: rtl/zbus_phase_timer.sv
module zbus_phase_timer #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [LEN_W-1:0] len,
  output logic             last
);

  logic [LEN_W-1:0] cnt_q;

  assign last = (cnt_q == len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!hold) cnt_q <= '0;
    else if (!last) cnt_q <= cnt_q + 1'b1;
  end

  // Counter never runs past the programmed phase length (R5).
  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < len);

endmodule

// File: rtl/zbus_seq.sv
module zbus_seq
  import zbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   wait_ok,
  input  logic   last,
  output phase_e phase_q,
  output phase_e phase_d,
  output logic   accept,
  output logic   capture
);

  assign accept  = (phase_q == PH_IDLE) && req_valid;
  assign capture = (phase_q == PH_T3) && last;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (req_valid) phase_d = PH_T1;
      PH_T1:   if (last) phase_d = PH_T2;
      PH_T2:   if (last) phase_d = wait_ok ? PH_T3 : PH_TW;
      PH_TW:   if (wait_ok) phase_d = PH_T3;
      PH_T3:   if (last) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assert_wait_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T2 && last && !wait_ok) |=> (phase_q == PH_TW));
  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TW && !wait_ok) |=> (phase_q == PH_TW));
  assert_wait_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TW && wait_ok) |=> (phase_q == PH_T3));
  assert_busy_ignores_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE && phase_q != PH_T3) |=> (phase_q != PH_T1 || $past(phase_q) == PH_T1));

endmodule

// File: rtl/zbus_pin_regs.sv
module zbus_pin_regs
  import zbus_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  phase_e   phase_d,
  input  logic     wr,
  input  logic     io,
  output bus_ctl_t ctl_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_IDLE;
    else        ctl_q <= ctl_for(phase_d, wr, io);
  end

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_q.rd_n == 1'b0 && ctl_q.wr_n == 1'b0));
  assert_space_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_q.mreq_n == 1'b0 && ctl_q.iorq_n == 1'b0));
  assert_strobe_needs_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.rd_n || !ctl_q.wr_n || ctl_q.oe) |-> !ctl_q.cs_n);

endmodule

// File: rtl/zbus_cycle_ctrl.sv
module zbus_cycle_ctrl
  import zbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_io,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [3:0]    cfg_clks,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_data_out,
  output logic          ext_data_oe,
  input  logic [DW-1:0] ext_data_in,
  output logic          ext_cs_n,
  output logic          ext_rd_n,
  output logic          ext_wr_n,
  output logic          ext_mreq_n,
  output logic          ext_iorq_n,
  input  logic          ext_wait_n
);

  localparam int LEN_W = 4;

  phase_e          phase_q, phase_d;
  logic            accept, capture, last, hold;
  logic            wait_q;
  logic            wr_q, io_q, cur_wr, cur_io;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q, rdata_q;
  logic [LEN_W-1:0] len_q;
  logic            done_q;
  bus_ctl_t        ctl_q;

  assign hold   = (phase_d == phase_q);
  assign cur_wr = accept ? req_write : wr_q;
  assign cur_io = accept ? req_io    : io_q;

  zbus_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .wait_ok   (wait_q),
    .last      (last),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .accept    (accept),
    .capture   (capture)
  );

  zbus_phase_timer #(.LEN_W(LEN_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (hold),
    .len   (len_q),
    .last  (last)
  );

  zbus_pin_regs u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_d (phase_d),
    .wr      (cur_wr),
    .io      (cur_io),
    .ctl_q   (ctl_q)
  );

  // Request fields are latched once, at acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      io_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      len_q   <= 4'd1;
    end else if (accept) begin
      wr_q    <= req_write;
      io_q    <= req_io;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      len_q   <= eff_len(cfg_clks);
    end
  end

  // Wait input register, read data capture and done pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q  <= 1'b1;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      wait_q <= ext_wait_n;
      done_q <= capture;
      if (capture && !wr_q) rdata_q <= ext_data_in;
    end
  end

  assign rsp_rdata    = rdata_q;
  assign rsp_done     = done_q;
  assign ext_addr     = addr_q;
  assign ext_data_out = wdata_q;
  assign ext_data_oe  = ctl_q.oe;
  assign ext_cs_n     = ctl_q.cs_n;
  assign ext_rd_n     = ctl_q.rd_n;
  assign ext_wr_n     = ctl_q.wr_n;
  assign ext_mreq_n   = ctl_q.mreq_n;
  assign ext_iorq_n   = ctl_q.iorq_n;

  assert_t3_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_T3) |-> $stable({ext_cs_n, ext_rd_n, ext_wr_n, ext_mreq_n, ext_iorq_n, ext_data_oe}));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  assert_done_bus_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (ext_cs_n && ext_rd_n && ext_wr_n && ext_mreq_n && ext_iorq_n));
  assert_addr_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_cs_n && !$past(ext_cs_n)) |-> $stable(ext_addr));

endmodule

// File: tb/sim_zbus_cycle_ctrl.sv
module sim_zbus_cycle_ctrl;
  localparam int CLK_P = 10;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [3:0] cfg_clks = 4'd1;
  logic [DW-1:0] rsp_rdata, ext_data_out;
  logic [DW-1:0] ext_data_in = '0;
  logic rsp_done, ext_data_oe, ext_cs_n, ext_rd_n, ext_wr_n, ext_mreq_n, ext_iorq_n;
  logic ext_wait_n = 1'b1;
  logic [AW-1:0] ext_addr;

  typedef struct {
    bit wr; bit io; logic [AW-1:0] addr; logic [DW-1:0] wdata;
    int n; int total; string len_req;
  } exp_t;
  exp_t q[$];
  int vec = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  zbus_cycle_ctrl #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata), .cfg_clks(cfg_clks),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .ext_addr(ext_addr),
    .ext_data_out(ext_data_out), .ext_data_oe(ext_data_oe), .ext_data_in(ext_data_in),
    .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_mreq_n(ext_mreq_n), .ext_iorq_n(ext_iorq_n), .ext_wait_n(ext_wait_n)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Value the model device puts on the bus at cs-low clock c.
  function automatic logic [DW-1:0] dev_val(input logic [AW-1:0] a, input int c);
    logic [DW-1:0] v;
    v = a[DW-1:0] + DW'(c * 17);
    return v;
  endfunction

  // Driver: issues one cycle and pushes the expected outcome.
  task automatic run(input bit wr, input bit io, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input int cfg, input int wl,
                     input bit stray, input bit b2b);
    exp_t e;
    int n, extra, c;
    n = (cfg == 0) ? 1 : cfg;
    extra = (wl >= 2*n - 1) ? (wl + 2 - 2*n) : 0;
    e.wr = wr; e.io = io; e.addr = a; e.wdata = d; e.n = n;
    e.total = 3*n + extra;
    e.len_req = (wl > 0) ? "R6" : "R5";
    if (!b2b) @(negedge clk);
    cfg_clks = 4'(cfg); req_write = wr; req_io = io; req_addr = a; req_wdata = d;
    req_valid = 1'b1;
    q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    c = 1;
    while (1) begin
      ext_data_in = dev_val(a, c);
      ext_wait_n = (c <= wl) ? 1'b0 : 1'b1;
      if (stray && c == 2) begin
        req_valid = 1'b1; req_addr = ~a; req_write = ~wr; req_io = ~io; cfg_clks = 4'd9;
      end
      if (stray && c == 3) req_valid = 1'b0;
      @(negedge clk);
      if (ext_cs_n) break;
      c++;
    end
    ext_wait_n = 1'b1;
  endtask

  // Monitor: checks the bus every clock and scores each completion.
  initial begin
    int c;
    exp_t e;
    c = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (!ext_cs_n) begin
        c++;
        e = q[0];
        check(ext_addr == e.addr, "R2", "addr", ext_addr, e.addr);
        check(ext_data_oe == e.wr, "R9", "oe", ext_data_oe, e.wr);
        if (e.wr) check(ext_data_out == e.wdata, "R9", "wdata", ext_data_out, e.wdata);
        check(!rsp_done, "R10", "done during cycle", rsp_done, 0);
        if (c <= e.n) begin
          check({ext_rd_n, ext_wr_n, ext_mreq_n, ext_iorq_n} == 4'hF, "R2", "T1 strobes",
                {ext_rd_n, ext_wr_n, ext_mreq_n, ext_iorq_n}, 4'hF);
        end else begin
          check(ext_rd_n == e.wr && ext_wr_n == !e.wr,
                (c > e.total - e.n) ? "R7" : "R3", "rd/wr",
                {ext_rd_n, ext_wr_n}, {e.wr, !e.wr});
          check(ext_mreq_n == e.io && ext_iorq_n == !e.io,
                (c > e.total - e.n) ? "R7" : "R4", "mreq/iorq",
                {ext_mreq_n, ext_iorq_n}, {e.io, !e.io});
        end
      end else if (rsp_done) begin
        if (q.size() == 0) begin
          check(0, "R10", "done with no cycle", 1, 0);
        end else begin
          e = q.pop_front();
          check(c == e.total, e.len_req, "cs-low clocks", c, e.total);
          if (!e.wr)
            check(rsp_rdata == dev_val(e.addr, e.total), "R8", "rdata",
                  rsp_rdata, dev_val(e.addr, e.total));
          check({ext_rd_n, ext_wr_n, ext_mreq_n, ext_iorq_n, ext_data_oe} == 5'b11110,
                "R10", "idle at done", {ext_rd_n, ext_wr_n, ext_mreq_n, ext_iorq_n, ext_data_oe},
                5'b11110);
        end
        c = 0;
      end else begin
        if (c != 0) check(0, "R10", "cycle ended without done", c, 0);
        c = 0;
        check(!ext_data_oe, "R9", "oe idle", ext_data_oe, 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({ext_cs_n, ext_rd_n, ext_wr_n, ext_mreq_n, ext_iorq_n} == 5'h1F, "R1", "strobes",
          {ext_cs_n, ext_rd_n, ext_wr_n, ext_mreq_n, ext_iorq_n}, 5'h1F);
    check(!ext_data_oe && !rsp_done, "R1", "oe/done", {ext_data_oe, rsp_done}, 0);
    check(ext_addr == 0 && rsp_rdata == 0, "R1", "addr/rdata", {ext_addr, rsp_rdata}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(0, 0, 16'h1230, 8'h00, 2, 0, 0, 0);  // R5 memory read
    run(1, 1, 16'h0045, 8'h5A, 1, 0, 0, 0);  // R9 I/O write
    run(0, 1, 16'h00F7, 8'h00, 0, 0, 0, 0);  // R5 zero setting
    run(1, 0, 16'h8001, 8'hC3, 3, 4, 0, 0);  // R6 wait too late
    run(0, 0, 16'h4411, 8'h00, 3, 5, 0, 0);  // R6 one wait
    run(0, 0, 16'h2202, 8'h00, 2, 9, 0, 0);  // R6 long wait
    run(1, 0, 16'hFFEE, 8'h99, 15, 0, 0, 0); // R5 longest phases
    run(0, 0, 16'h3C3C, 8'h00, 2, 0, 1, 0);  // R11 stray request
    run(1, 1, 16'h0077, 8'h18, 1, 0, 0, 0);  // R10 back-to-back pair
    run(0, 1, 16'h0078, 8'h00, 1, 0, 0, 1);
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R10", "cycles left open", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vec++; bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule